// File: doc/BRIEF.md
# Masked Interrupt Enable and Pending Unit

This block collects two hardware events, a blitter completion and a vertical blank, into a pending register. It drives one level-sensitive interrupt line whenever a pending bit is also enabled. Software reaches the block through a byte-wide port. An enable word sits at byte offsets 0x600 to 0x603. A pending word sits at byte offsets 0x604 to 0x607. Within each word, byte k holds bits 8k+7 down to 8k. Only bits 31, 14 and 6 (mask 0x80004040) exist. Every other bit ignores writes and reads back as zero.

The pending word is cleared by writing ones to it. The enable word is written directly. The interrupt line is a held register. It takes a new value only when an event arrives or when software writes the pending byte at 0x605 or at 0x607. Any other write leaves the line as it was, even when that write changes the enable or pending contents. This keeps the strict update points that the surrounding driver expects.

Top module: `irq_mask_unit`

## Requirements
- R1: After a synchronous reset, both words read as zero, `irq` is low and `rd_data` is zero.
- R2: Bits outside mask 0x80004040 always read as zero, whatever value is written to them.
- R3: A write to offset 0x600+k (k = 0..3) loads byte k of the enable word with `wr_data` AND the matching mask byte.
- R4: A write to offset 0x604+k clears each pending bit of byte k where `wr_data` holds a one. Pending bits where `wr_data` holds a zero keep their value.
- R5: A pulse on `evt_blit_done` sets pending bit 31, and a pulse on `evt_vblank` sets pending bit 14. Both bits stay set until software clears them.
- R6: When an event and a software clear reach the same pending bit in the same cycle, the bit ends up set.
- R7: In a cycle that has an event, or a write to offset 0x605 or 0x607, `irq` takes the value of the OR of (enable AND pending AND mask) as it stands after that cycle's updates. The new value is visible one clock later.
- R8: In any other cycle `irq` holds its value. This includes cycles with writes to the enable word and writes to offsets 0x604 or 0x606.
- R9: Writes to addresses outside 0x600 to 0x607 change nothing, and reads from those addresses return zero.
- R10: A read with `rd_en` high returns the addressed byte, as it stood before that cycle's write, on `rd_data` one clock later. `rd_data` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 12 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 12 | Byte read address |
| rd_data | output | 8 | Registered read data |
| evt_blit_done | input | 1 | Blitter completion event, one-cycle pulse |
| evt_vblank | input | 1 | Vertical blank event, one-cycle pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- each enable byte write lands, with the mask applied;
- a written one never leaves a pending bit set unless an event also hit that bit;
- each event sets its pending bit;
- `irq` stays stable outside refresh cycles;
- `irq` matches the registered enable and pending state after each refresh.

Only the bench scenarios can show the following:
- the deliberately stale `irq` after enable writes and after clears at 0x604;
- read timing relative to a write in the same cycle;
- the behaviour of addresses outside the window.

The bench checks these against a reference model under random traffic and targeted corner cases.

// File: rtl/irq_mask_unit_pkg.sv
package irq_mask_unit_pkg;
  localparam int REG_W     = 32;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = REG_W / LANE_W;
  localparam int LANE_SEL_W = $clog2(NUM_LANES);

  typedef logic [REG_W-1:0]     word_t;
  typedef logic [NUM_LANES-1:0] lane_vec_t;
endpackage

// File: rtl/irq_lane_decode.sv
module irq_lane_decode
  import irq_mask_unit_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter logic [11:0] BASE   = 12'h600
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output lane_vec_t         en_lane_we,
  output lane_vec_t         st_lane_we
);
  localparam int WIN_LSB = LANE_SEL_W + 1;
  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE);

  logic in_win;
  assign in_win = wr_en && (wr_addr[ADDR_W-1:WIN_LSB] == BASE_W[ADDR_W-1:WIN_LSB]);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic lane_hit;
    assign lane_hit      = in_win && (wr_addr[LANE_SEL_W-1:0] == LANE_SEL_W'(g));
    assign en_lane_we[g] = lane_hit && !wr_addr[LANE_SEL_W];
    assign st_lane_we[g] = lane_hit &&  wr_addr[LANE_SEL_W];
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_mask_unit_pkg::*;
#(
  parameter logic [31:0] IMPL_MASK = 32'h8000_4040
) (
  input  logic              clk,
  input  logic              rst,
  input  lane_vec_t         lane_we,
  input  logic [LANE_W-1:0] wr_data,
  output word_t             en_d,
  output word_t             en_q
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam logic [LANE_W-1:0] LM = IMPL_MASK[g*LANE_W +: LANE_W];
    assign en_d[g*LANE_W +: LANE_W] = lane_we[g] ? (wr_data & LM)
                                                 : en_q[g*LANE_W +: LANE_W];

    // R3
    en_lane_load_chk: assert property (@(posedge clk) disable iff (rst)
      lane_we[g] |=> en_q[g*LANE_W +: LANE_W] == ($past(wr_data) & LM));
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_mask_unit_pkg::*;
#(
  parameter logic [31:0] IMPL_MASK = 32'h8000_4040
) (
  input  logic              clk,
  input  logic              rst,
  input  lane_vec_t         lane_we,
  input  logic [LANE_W-1:0] wr_data,
  input  word_t             set_vec,
  output word_t             st_d,
  output word_t             st_q
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam logic [LANE_W-1:0] LM = IMPL_MASK[g*LANE_W +: LANE_W];
    logic [LANE_W-1:0] clr;
    assign clr = lane_we[g] ? wr_data : '0;
    // set after clear: an event beats a simultaneous clear
    assign st_d[g*LANE_W +: LANE_W] =
      ((st_q[g*LANE_W +: LANE_W] & ~clr) | set_vec[g*LANE_W +: LANE_W]) & LM;

    // R4
    st_w1c_chk: assert property (@(posedge clk) disable iff (rst)
      lane_we[g] |=> (st_q[g*LANE_W +: LANE_W] & $past(wr_data)
                      & ~$past(set_vec[g*LANE_W +: LANE_W])) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/irq_out_eval.sv
module irq_out_eval
  import irq_mask_unit_pkg::*;
#(
  parameter logic [31:0] IMPL_MASK = 32'h8000_4040
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  refresh,
  input  word_t en_d,
  input  word_t st_d,
  output logic  irq
);
  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (refresh) irq <= |(en_d & st_d & IMPL_MASK);
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_unit_pkg::*;
#(
  parameter int          ADDR_W        = 12,
  parameter logic [11:0] BASE          = 12'h600,
  parameter logic [31:0] IMPL_MASK     = 32'h8000_4040,
  parameter int          DONE_BIT      = 31,
  parameter int          VBL_BIT       = 14,
  parameter logic [3:0]  REFRESH_LANES = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              evt_blit_done,
  input  logic              evt_vblank,
  output logic              irq
);
  localparam int WIN_LSB = LANE_SEL_W + 1;
  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE);

  lane_vec_t en_we, st_we;
  word_t     en_d, en_q, st_d, st_q, set_vec;
  logic      refresh;

  irq_lane_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .en_lane_we(en_we), .st_lane_we(st_we));

  irq_enable_reg #(.IMPL_MASK(IMPL_MASK)) u_en (
    .clk(clk), .rst(rst), .lane_we(en_we), .wr_data(wr_data),
    .en_d(en_d), .en_q(en_q));

  always_comb begin
    set_vec = '0;
    set_vec[DONE_BIT] = evt_blit_done;
    set_vec[VBL_BIT]  = evt_vblank;
  end

  irq_status_reg #(.IMPL_MASK(IMPL_MASK)) u_st (
    .clk(clk), .rst(rst), .lane_we(st_we), .wr_data(wr_data),
    .set_vec(set_vec), .st_d(st_d), .st_q(st_q));

  assign refresh = evt_blit_done || evt_vblank || (|(st_we & REFRESH_LANES));

  irq_out_eval #(.IMPL_MASK(IMPL_MASK)) u_out (
    .clk(clk), .rst(rst), .refresh(refresh),
    .en_d(en_d), .st_d(st_d), .irq(irq));

  logic  rd_hit;
  word_t rd_word;
  assign rd_hit  = rd_addr[ADDR_W-1:WIN_LSB] == BASE_W[ADDR_W-1:WIN_LSB];
  assign rd_word = rd_addr[LANE_SEL_W] ? st_q : en_q;

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_hit ? rd_word[{rd_addr[LANE_SEL_W-1:0], 3'b000} +: 8] : 8'h00;
  end

  // R5
  done_sets_chk: assert property (@(posedge clk) disable iff (rst)
    evt_blit_done |=> st_q[DONE_BIT]);
  // R5
  vbl_sets_chk: assert property (@(posedge clk) disable iff (rst)
    evt_vblank |=> st_q[VBL_BIT]);
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !refresh |=> $stable(irq));
  // R7
  irq_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    refresh |=> irq == |(en_q & st_q & IMPL_MASK));
  // R2
  impl_only_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_q | st_q) & ~IMPL_MASK) == '0);
endmodule

// File: tb/irq_mask_unit_test.sv
module irq_mask_unit_test;
  localparam logic [31:0] MASK = 32'h8000_4040;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, evt_blit_done = 0, evt_vblank = 0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq;

  int total = 0, bad = 0;
  logic [31:0] m_en = '0, m_st = '0;
  logic        m_irq = 1'b0;
  logic [7:0]  m_rd = '0;

  always #2 clk = ~clk;

  irq_mask_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_blit_done(evt_blit_done), .evt_vblank(evt_vblank), .irq(irq));

  function automatic logic [7:0] model_byte(logic [11:0] a, logic [31:0] en, logic [31:0] st);
    if (a >= 12'h600 && a <= 12'h603) return en[(a - 12'h600)*8 +: 8];
    if (a >= 12'h604 && a <= 12'h607) return st[(a - 12'h604)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, update the model, compare irq and read data
  task automatic step(input logic w, input logic [11:0] wa, input logic [7:0] wd,
                      input logic r, input logic [11:0] ra,
                      input logic eb, input logic ev, input string tag);
    logic [31:0] en_n, st_n;
    logic        refr;
    @(negedge clk);
    wr_en = w; wr_addr = wa; wr_data = wd; rd_en = r; rd_addr = ra;
    evt_blit_done = eb; evt_vblank = ev;
    if (r) m_rd = model_byte(ra, m_en, m_st);
    en_n = m_en; st_n = m_st;
    refr = eb || ev || (w && (wa == 12'h605 || wa == 12'h607));
    if (w && wa >= 12'h600 && wa <= 12'h603) en_n[(wa - 12'h600)*8 +: 8] = wd;
    if (w && wa >= 12'h604 && wa <= 12'h607) st_n[(wa - 12'h604)*8 +: 8] &= ~wd;
    if (eb) st_n[31] = 1'b1;
    if (ev) st_n[14] = 1'b1;
    m_en = en_n & MASK; m_st = st_n & MASK;
    if (refr) m_irq = |(m_en & m_st);
    @(posedge clk); #1;
    check(tag, {31'b0, irq}, {31'b0, m_irq});
    check(tag, {24'b0, rd_data}, {24'b0, m_rd});
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d, string tag);
    step(1, a, d, 0, 12'h0, 0, 0, tag);
  endtask
  task automatic rd(logic [11:0] a, logic [7:0] exp, string tag);
    step(0, 12'h0, 8'h0, 1, a, 0, 0, tag);
    check(tag, {24'b0, rd_data}, {24'b0, exp});
  endtask
  task automatic ev(logic b, logic v, string tag);
    step(0, 12'h0, 8'h0, 0, 12'h0, b, v, tag);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check("R1", {31'b0, irq}, 32'd0);
    check("R1", {24'b0, rd_data}, 32'd0);
    for (int a = 12'h600; a < 12'h608; a++) rd(12'(a), 8'h00, "R1");
    // R2 / R3: unimplemented bits read zero, lane mapping of enable word
    wr(12'h600, 8'hFF, "R3"); rd(12'h600, 8'h40, "R2");
    wr(12'h602, 8'hFF, "R2"); rd(12'h602, 8'h00, "R2");
    wr(12'h603, 8'hFF, "R3"); rd(12'h603, 8'h80, "R3");
    wr(12'h603, 8'h00, "R3"); rd(12'h603, 8'h00, "R3");
    // R5: events set pending bits; enables off so irq stays low
    ev(1, 0, "R5"); rd(12'h607, 8'h80, "R5");
    ev(0, 1, "R5"); rd(12'h605, 8'h40, "R5");
    check("R7", {31'b0, irq}, 32'd0);
    // R8: enabling does not refresh irq
    wr(12'h603, 8'h80, "R8"); check("R8", {31'b0, irq}, 32'd0);
    // R7: write of zero to 0x607 refreshes without clearing
    wr(12'h607, 8'h00, "R7"); check("R7", {31'b0, irq}, 32'd1);
    rd(12'h607, 8'h80, "R4");
    // R8: disabling keeps irq high until refresh
    wr(12'h603, 8'h00, "R8"); check("R8", {31'b0, irq}, 32'd1);
    wr(12'h605, 8'h00, "R7"); check("R7", {31'b0, irq}, 32'd0);
    // R4: clear vblank bit
    wr(12'h605, 8'h40, "R4"); rd(12'h605, 8'h00, "R4");
    // R6: event and clear in the same cycle
    step(1, 12'h607, 8'h80, 0, 12'h0, 1, 0, "R6"); rd(12'h607, 8'h80, "R6");
    // R9: writes outside the window ignored, reads return zero
    wr(12'h608, 8'hFF, "R9"); wr(12'h5FF, 8'hFF, "R9"); wr(12'h203, 8'hFF, "R9");
    rd(12'h603, 8'h00, "R9"); rd(12'h607, 8'h80, "R9"); rd(12'h60C, 8'h00, "R9");
    // R10: read sees pre-write value, then holds
    wr(12'h600, 8'h00, "R10");
    step(1, 12'h600, 8'h40, 1, 12'h600, 0, 0, "R10");
    check("R10", {24'b0, rd_data}, 32'h00);
    step(0, 12'h0, 8'h0, 0, 12'h600, 0, 0, "R10");
    check("R10", {24'b0, rd_data}, 32'h00);
    rd(12'h600, 8'h40, "R10");
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a, ra;
      a  = 12'h5FC + 12'($urandom_range(0, 15));
      ra = 12'h5FC + 12'($urandom_range(0, 15));
      step($urandom_range(0, 2) != 0, a, 8'($urandom()),
           $urandom_range(0, 1) == 1, ra,
           $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, "R7");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule